// File: doc/BRIEF.md
# Floating-Point Operation Dispatcher and Sequencer

This block is the control layer at the top of a 64-bit floating-point unit. It takes two operands, a two-bit operation code and a level enable. On the clock edge where enable is first sampled high it latches the operands and decides which arithmetic unit does the work. The adder and the subtractor operate on magnitudes only, so the choice between them depends on the operation and on the operand signs. The block computes the sign of the final result itself, strips the signs from the operands it hands to the units, and for the subtractor puts the larger magnitude first so that the difference is never negative.

A cycle counter starts on the capture edge. Its terminal value depends on the unit that executes the operation. When the counter reaches that value, `ready` rises and `result` carries the corrected sign joined to the chosen unit's magnitude. The arithmetic units sit outside this block as fixed-latency engines. Each one samples its operands on a one-cycle start pulse and presents its result on a dedicated input.

Top module: `fpop_dispatch`

## Requirements
- R1: After reset, `ready` is 0, `unit_start` is 0 and `result` is 0.
- R2: Operation code 00 (add) with equal operand signs (bit 63) is sent to the adder (start bit 0), and the result sign is A's sign.
- R3: Operation code 00 with opposite signs is sent to the subtractor (start bit 1). The result sign is that of the operand with the larger magnitude (bits 62:0), or 0 when the magnitudes are equal.
- R4: Operation code 01 (subtract A minus B) with opposite signs is sent to the adder, and the result sign is A's sign.
- R5: Operation code 01 with equal signs is sent to the subtractor. The result sign is A's sign when |A| > |B|, the inverse of B's sign when |B| > |A|, and 0 when the magnitudes are equal.
- R6: Operation codes 10 (multiply) and 11 (divide) are sent to start bits 2 and 3 respectively, and the result sign is the XOR of the operand signs.
- R7: `unit_a` and `unit_b` always have bit 63 cleared. For the subtractor, `unit_a` carries the larger magnitude. For every other unit it carries A's magnitude.
- R8: `unit_start` is a single-cycle, one-hot pulse. It is high in the cycle after the capture edge.
- R9: `ready` rises after exactly N rising edges that sampled enable high, counting the capture edge. N is 20 for the adder, 21 for the subtractor, 24 for the multiplier and 71 for the divider. N depends on the unit that executes the operation.
- R10: While enable stays high, `ready` stays high once it has risen. The first edge that samples enable low clears `ready` and the counter.
- R11: Changes to `opa`, `opb` and `op_sel` after the capture edge do not affect the routing, the unit operands or `result` of the running operation.
- R12: While `ready` is high, `result` equals the corrected sign joined to bits 62:0 of the selected unit's result. While `ready` is low, `result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Level request; its rise captures a new operation |
| op_sel | input | 2 | 00 add, 01 subtract, 10 multiply, 11 divide |
| opa | input | 64 | Operand A, IEEE double layout |
| opb | input | 64 | Operand B, IEEE double layout |
| add_res | input | 64 | Magnitude result from the adder |
| sub_res | input | 64 | Magnitude result from the subtractor |
| mul_res | input | 64 | Magnitude result from the multiplier |
| div_res | input | 64 | Magnitude result from the divider |
| unit_start | output | 4 | One-hot start pulse: adder, subtractor, multiplier, divider |
| unit_a | output | 64 | First operand magnitude to the units |
| unit_b | output | 64 | Second operand magnitude to the units |
| result | output | 64 | Signed result, valid with ready |
| ready | output | 1 | Result valid |

## Verification
The assertions check properties that hold on every cycle:
- the start pulse is one-hot and lasts one cycle;
- the unit operands carry no sign, and the subtractor operands are ordered;
- ready stays up while enable is held and drops after enable falls;
- result is stable while ready is held and zero while ready is low;
- a counter in the checker confirms that ready rises at the latency of the unit that was started.

The routing choice and the corrected sign for each combination of operation, signs and magnitude ordering can only be shown by the bench. It sweeps all four operations, all four sign pairs and three magnitude relations, and it scrambles the inputs while each operation is counting.

// File: rtl/fpop_dispatch_pkg.sv
package fpop_dispatch_pkg;

  typedef enum logic [1:0] {
    OPC_ADD = 2'd0,
    OPC_SUB = 2'd1,
    OPC_MUL = 2'd2,
    OPC_DIV = 2'd3
  } opcode_e;

  typedef enum logic [1:0] {
    EU_ADDER = 2'd0,
    EU_SUBTR = 2'd1,
    EU_MULT  = 2'd2,
    EU_DIVID = 2'd3
  } exec_unit_e;

  localparam int unsigned NUM_UNITS = 4;

  typedef struct packed {
    exec_unit_e unit;
    logic       sign;
    logic       swap;
  } route_t;

  // Unit that actually performs the work, given the operation and signs.
  function automatic exec_unit_e choose_unit(opcode_e op, logic sa, logic sb);
    exec_unit_e u;
    case (op)
      OPC_ADD: u = (sa == sb) ? EU_ADDER : EU_SUBTR;
      OPC_SUB: u = (sa != sb) ? EU_ADDER : EU_SUBTR;
      OPC_MUL: u = EU_MULT;
      default: u = EU_DIVID;
    endcase
    return u;
  endfunction

  // Sign of the final result once the unit has produced a magnitude.
  function automatic logic final_sign(opcode_e op, exec_unit_e u, logic sa,
                                      logic sb, logic a_bigger, logic same_mag);
    logic s;
    logic b_eff;
    b_eff = sb ^ (op == OPC_SUB);
    case (u)
      EU_ADDER: s = sa;
      EU_SUBTR: s = same_mag ? 1'b0 : (a_bigger ? sa : b_eff);
      default:  s = sa ^ sb;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/fpd_route_decode.sv
module fpd_route_decode
  import fpop_dispatch_pkg::*;
#(
  parameter int unsigned W = 64
) (
  input  logic [1:0]   op_sel,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output route_t       route,
  output logic [W-2:0] mag_first,
  output logic [W-2:0] mag_second
);

  localparam int unsigned MW = W - 1;

  logic [MW-1:0] mag_a;
  logic [MW-1:0] mag_b;
  logic          sign_a;
  logic          sign_b;
  logic          a_bigger;
  logic          same_mag;
  opcode_e       op;
  exec_unit_e    unit;

  assign mag_a    = opa[MW-1:0];
  assign mag_b    = opb[MW-1:0];
  assign sign_a   = opa[W-1];
  assign sign_b   = opb[W-1];
  assign a_bigger = mag_a > mag_b;
  assign same_mag = mag_a == mag_b;
  assign op       = opcode_e'(op_sel);
  assign unit     = choose_unit(op, sign_a, sign_b);

  always_comb begin
    route.unit = unit;
    route.sign = final_sign(op, unit, sign_a, sign_b, a_bigger, same_mag);
    route.swap = (unit == EU_SUBTR) && !a_bigger && !same_mag;
  end

  assign mag_first  = route.swap ? mag_b : mag_a;
  assign mag_second = route.swap ? mag_a : mag_b;

endmodule

// File: rtl/fpd_operand_hold.sv
module fpd_operand_hold
  import fpop_dispatch_pkg::*;
#(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  route_t       route_in,
  input  logic [W-2:0] first_in,
  input  logic [W-2:0] second_in,
  output route_t       route_q,
  output logic [W-2:0] first_q,
  output logic [W-2:0] second_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      route_q  <= '{unit: EU_ADDER, sign: 1'b0, swap: 1'b0};
      first_q  <= '0;
      second_q <= '0;
    end else if (load) begin
      route_q  <= route_in;
      first_q  <= first_in;
      second_q <= second_in;
    end
  end

endmodule

// File: rtl/fpd_cycle_timer.sv
module fpd_cycle_timer
  import fpop_dispatch_pkg::*;
#(
  parameter int unsigned LAT_ADD = 20,
  parameter int unsigned LAT_SUB = 21,
  parameter int unsigned LAT_MUL = 24,
  parameter int unsigned LAT_DIV = 71
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       en_rise,
  input  exec_unit_e unit,
  output logic       start_now,
  output logic       ready
);

  localparam int unsigned MAX_AS = (LAT_ADD > LAT_SUB) ? LAT_ADD : LAT_SUB;
  localparam int unsigned MAX_MD = (LAT_MUL > LAT_DIV) ? LAT_MUL : LAT_DIV;
  localparam int unsigned MAX_LAT = (MAX_AS > MAX_MD) ? MAX_AS : MAX_MD;
  localparam int unsigned CW = $clog2(MAX_LAT + 1);

  logic          active_q;
  logic [CW-1:0] count_q;
  logic [CW-1:0] limit;
  logic          at_limit;

  always_comb begin
    case (unit)
      EU_ADDER: limit = CW'(LAT_ADD);
      EU_SUBTR: limit = CW'(LAT_SUB);
      EU_MULT:  limit = CW'(LAT_MUL);
      default:  limit = CW'(LAT_DIV);
    endcase
  end

  assign at_limit = count_q == limit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      count_q  <= '0;
    end else if (!enable) begin
      active_q <= 1'b0;
      count_q  <= '0;
    end else if (en_rise) begin
      active_q <= 1'b1;
      count_q  <= CW'(1);
    end else if (active_q && !at_limit) begin
      count_q  <= count_q + CW'(1);
    end
  end

  assign start_now = active_q && (count_q == CW'(1));
  assign ready     = active_q && at_limit;

endmodule

// File: rtl/fpd_result_merge.sv
module fpd_result_merge
  import fpop_dispatch_pkg::*;
#(
  parameter int unsigned W = 64
) (
  input  exec_unit_e   unit,
  input  logic         sign,
  input  logic         ready,
  input  logic [W-1:0] add_res,
  input  logic [W-1:0] sub_res,
  input  logic [W-1:0] mul_res,
  input  logic [W-1:0] div_res,
  output logic [W-1:0] result
);

  logic [W-1:0] picked;

  always_comb begin
    case (unit)
      EU_ADDER: picked = add_res;
      EU_SUBTR: picked = sub_res;
      EU_MULT:  picked = mul_res;
      default:  picked = div_res;
    endcase
  end

  assign result = ready ? {sign, picked[W-2:0]} : '0;

endmodule

// File: rtl/fpop_dispatch.sv
module fpop_dispatch
  import fpop_dispatch_pkg::*;
#(
  parameter int unsigned W       = 64,
  parameter int unsigned LAT_ADD = 20,
  parameter int unsigned LAT_SUB = 21,
  parameter int unsigned LAT_MUL = 24,
  parameter int unsigned LAT_DIV = 71
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic [1:0]           op_sel,
  input  logic [W-1:0]         opa,
  input  logic [W-1:0]         opb,
  input  logic [W-1:0]         add_res,
  input  logic [W-1:0]         sub_res,
  input  logic [W-1:0]         mul_res,
  input  logic [W-1:0]         div_res,
  output logic [NUM_UNITS-1:0] unit_start,
  output logic [W-1:0]         unit_a,
  output logic [W-1:0]         unit_b,
  output logic [W-1:0]         result,
  output logic                 ready
);

  logic         en_q;
  logic         en_rise;
  route_t       route_d;
  route_t       route_q;
  logic [W-2:0] first_d;
  logic [W-2:0] second_d;
  logic [W-2:0] first_q;
  logic [W-2:0] second_q;
  logic         start_now;

  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= enable;
  end

  assign en_rise = enable && !en_q;

  fpd_route_decode #(.W(W)) decode_i (
    .op_sel    (op_sel),
    .opa       (opa),
    .opb       (opb),
    .route     (route_d),
    .mag_first (first_d),
    .mag_second(second_d)
  );

  fpd_operand_hold #(.W(W)) hold_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (en_rise),
    .route_in (route_d),
    .first_in (first_d),
    .second_in(second_d),
    .route_q  (route_q),
    .first_q  (first_q),
    .second_q (second_q)
  );

  fpd_cycle_timer #(
    .LAT_ADD(LAT_ADD),
    .LAT_SUB(LAT_SUB),
    .LAT_MUL(LAT_MUL),
    .LAT_DIV(LAT_DIV)
  ) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .en_rise  (en_rise),
    .unit     (route_q.unit),
    .start_now(start_now),
    .ready    (ready)
  );

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_start
    assign unit_start[u] = start_now && (route_q.unit == exec_unit_e'(u));
  end

  assign unit_a = {1'b0, first_q};
  assign unit_b = {1'b0, second_q};

  fpd_result_merge #(.W(W)) merge_i (
    .unit   (route_q.unit),
    .sign   (route_q.sign),
    .ready  (ready),
    .add_res(add_res),
    .sub_res(sub_res),
    .mul_res(mul_res),
    .div_res(div_res),
    .result (result)
  );

endmodule

// File: rtl/fpop_dispatch_sva.sv
module fpop_dispatch_sva #(
  parameter int unsigned W       = 64,
  parameter int unsigned LAT_ADD = 20,
  parameter int unsigned LAT_SUB = 21,
  parameter int unsigned LAT_MUL = 24,
  parameter int unsigned LAT_DIV = 71
) (
  input logic         clk,
  input logic         rst_n,
  input logic         enable,
  input logic [3:0]   unit_start,
  input logic [W-1:0] unit_a,
  input logic [W-1:0] unit_b,
  input logic [W-1:0] result,
  input logic         ready
);

  localparam int unsigned CCW = 8;

  logic           en_prev;
  logic [CCW-1:0] cyc_q;
  logic [3:0]     sel_q;
  logic [CCW-1:0] want;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_prev <= 1'b0;
      cyc_q   <= '0;
      sel_q   <= '0;
    end else begin
      en_prev <= enable;
      if (!enable)                     cyc_q <= '0;
      else if (!en_prev)               cyc_q <= CCW'(1);
      else if (cyc_q != {CCW{1'b1}})   cyc_q <= cyc_q + CCW'(1);
      if (|unit_start) sel_q <= unit_start;
    end
  end

  always_comb begin
    case (sel_q)
      4'b0001: want = CCW'(LAT_ADD);
      4'b0010: want = CCW'(LAT_SUB);
      4'b0100: want = CCW'(LAT_MUL);
      default: want = CCW'(LAT_DIV);
    endcase
  end

  AST_START_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(unit_start)); // R8
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (|unit_start) |=> !(|unit_start)); // R8
  AST_MAG_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !unit_a[W-1] && !unit_b[W-1]); // R7
  AST_SUB_ORDERED: assert property (@(posedge clk) disable iff (!rst_n)
    unit_start[1] |-> (unit_a >= unit_b)); // R7
  AST_READY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && enable) |=> ready); // R10
  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !ready); // R10
  AST_RESULT_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && enable) |=> $stable(result)); // R11
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (result == '0)); // R12
  AST_LATENCY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (cyc_q == want)); // R9

endmodule

bind fpop_dispatch fpop_dispatch_sva #(
  .W(W), .LAT_ADD(LAT_ADD), .LAT_SUB(LAT_SUB), .LAT_MUL(LAT_MUL), .LAT_DIV(LAT_DIV)
) sva_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .unit_start(unit_start),
  .unit_a    (unit_a),
  .unit_b    (unit_b),
  .result    (result),
  .ready     (ready)
);

// File: tb/fpop_dispatch_tb_top.sv
module fpop_dispatch_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [1:0]  op_sel = 2'd0;
  logic [63:0] opa = '0;
  logic [63:0] opb = '0;
  logic [62:0] r_add = '0, r_sub = '0, r_mul = '0, r_div = '0;
  logic [3:0]  unit_start;
  logic [63:0] unit_a, unit_b, result;
  logic        ready;
  int          total = 0;
  int          bad = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  fpop_dispatch dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .op_sel(op_sel),
    .opa(opa), .opb(opb),
    .add_res({1'b0, r_add}), .sub_res({1'b0, r_sub}),
    .mul_res({1'b0, r_mul}), .div_res({1'b0, r_div}),
    .unit_start(unit_start), .unit_a(unit_a), .unit_b(unit_b),
    .result(result), .ready(ready)
  );

  function automatic logic [62:0] model(int u, logic [62:0] x, logic [62:0] y);
    case (u)
      0:       return x + y;
      1:       return x - y;
      2:       return x ^ (y << 1);
      default: return x - (y >> 2);
    endcase
  endfunction

  always @(posedge clk) begin
    if (unit_start[0]) r_add <= model(0, unit_a[62:0], unit_b[62:0]);
    if (unit_start[1]) r_sub <= model(1, unit_a[62:0], unit_b[62:0]);
    if (unit_start[2]) r_mul <= model(2, unit_a[62:0], unit_b[62:0]);
    if (unit_start[3]) r_div <= model(3, unit_a[62:0], unit_b[62:0]);
  end

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_one(int op, bit sa, bit sb, int rel, int seed);
    logic [62:0] ma, mb, ea, eb;
    int          unit, lat;
    bit          s, early, late;
    logic [63:0] exp_res, held;
    string       tag;
    ma = 63'h4003_0000_0000_0000 + 63'(seed * 4099);
    mb = 63'h3FF8_0000_0000_0000 + 63'(seed * 17);
    if (rel == 1) begin logic [62:0] t; t = ma; ma = mb; mb = t; end
    if (rel == 2) mb = ma;
    // Independent routing and sign rules
    if (op == 0) begin
      unit = (sa == sb) ? 0 : 1;
      tag = (unit == 0) ? "R2" : "R3";
    end else if (op == 1) begin
      unit = (sa != sb) ? 0 : 1;
      tag = (unit == 0) ? "R4" : "R5";
    end else begin
      unit = op;
      tag = "R6";
    end
    if (unit == 0) s = sa;
    else if (unit == 1) begin
      if (ma == mb) s = 1'b0;
      else if (ma > mb) s = sa;
      else s = (op == 1) ? ~sb : sb;
    end else s = sa ^ sb;
    if (unit == 1 && mb > ma) begin ea = mb; eb = ma; end
    else begin ea = ma; eb = mb; end
    lat = (unit == 0) ? 20 : (unit == 1) ? 21 : (unit == 2) ? 24 : 71;
    exp_res = {s, model(unit, ea, eb)};

    @(negedge clk);
    op_sel = 2'(op);
    opa = {sa, ma};
    opb = {sb, mb};
    enable = 1'b1;
    early = 0;
    late = 0;
    for (int i = 1; i <= lat + 3; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (i == 1) begin
        check(unit_start == 4'(1 << unit), "R8 start", {60'd0, unit_start}, 64'(1 << unit));
        check(unit_a == {1'b0, ea} && unit_b == {1'b0, eb}, "R7 operands",
              unit_a ^ unit_b, {1'b0, ea} ^ {1'b0, eb});
        check(result == '0, "R12 idle result", result, 64'd0);
      end
      if (i == 2) begin
        // R11: scramble inputs mid-count
        op_sel = ~op_sel;
        opa = ~opa;
        opb = opb ^ 64'h8000_0000_0F0F_0000;
        check(unit_start == 4'd0, "R8 pulse width", {60'd0, unit_start}, 64'd0);
      end
      if (i < lat && ready) early = 1;
      if (i >= lat && !ready) late = 1;
      if (i == lat) begin
        check(result == exp_res, tag, result, exp_res);
        held = result;
      end
      if (i == lat + 3)
        check(result == held && unit_a == {1'b0, ea}, "R11 held result", result, held);
    end
    check(!early && !late, "R9 latency", {62'd0, early, late}, 64'd0);
    check(!late, "R10 ready held", {63'd0, late}, 64'd0);
    enable = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(!ready && result == '0, "R10 drop", {63'd0, ready}, 64'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!ready && unit_start == 4'd0 && result == '0, "R1 reset",
          {59'd0, ready, unit_start}, 64'd0);
    rst_n = 1'b1;
    for (int op = 0; op < 4; op++)
      for (int sg = 0; sg < 4; sg++)
        for (int rel = 0; rel < 3; rel++)
          run_one(op, sg[1], sg[0], rel, op * 12 + sg * 3 + rel);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule